// File: doc/BRIEF.md
# Serial Flash Command Slave

This block answers byte-wide transfers as a small serial flash device would. A shift stage outside the block assembles bytes. It presents each byte with a single-cycle strobe while chip select is low. For every accepted byte, the block returns one reply byte on the following cycle. The first byte after selection is the command. Read and write commands then take a 24-bit address over three bytes, most significant byte first. After the address, data bytes are read from or stored into an internal RAM, and the address steps up by one after each data byte.

A status byte holds a write-enable latch in bit 1. Other commands set this latch, clear it or read it back. Stores happen only while the latch is set. The latch drops when a write transaction ends. Raising chip select ends any transaction and discards the latched command. The RAM depth is a parameter, and the address wraps on its low bits.

Top module: `sfl_flash_slave`

## Requirements
- R1: After reset, tx_valid and tx_byte are 0 and the write-enable latch (status bit 1) is clear.
- R2: Each byte strobed with cs_n low produces tx_valid high for exactly the next cycle, with the reply in tx_byte; the first such byte after selection is taken as the command.
- R3: Commands 0x02 and 0x03 are followed by three address bytes, most significant first; replies to the command byte and to the address bytes are 0x00.
- R4: Under command 0x03, each byte after the address returns the RAM byte at the current address, and the address then increments; only the low MEM_AW address bits (8 by default) select the RAM byte, so the address wraps.
- R5: Under command 0x02 with the latch set, each byte after the address is stored at the current address, and the address then increments.
- R6: Under command 0x02 with the latch clear, no byte is stored.
- R7: Command 0x06 sets the latch; under command 0x05 every further byte returns the status byte, which is 0x02 when the latch is set and 0x00 otherwise.
- R8: Command 0x04 clears the latch.
- R9: When cs_n rises on a transaction whose command was 0x02, the latch clears.
- R10: Any other command byte returns 0x00 on all following bytes and changes neither RAM nor status.
- R11: While cs_n is high, byte strobes are ignored (no reply, no store), and the latched command is dropped so the next byte after reselection is a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Reply present, one cycle after an accepted strobe |
| tx_byte | output | 8 | Reply byte |

## Verification
Two events can coincide: chip select rising and a data byte strobe under the write command in the same cycle. The bench forces this by raising cs_n in the same cycle as a write byte aimed at a RAM location that already holds a known value. The deselect must win, so the bench expects no reply, an unchanged value at that location, and a cleared latch on the next status read.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  localparam int ADDR_BYTES = 3;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int CNT_W      = $clog2(ADDR_W + 1);

  localparam logic [7:0] OP_STORE = 8'h02;
  localparam logic [7:0] OP_FETCH = 8'h03;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WEN   = 8'h06;

  // append one received byte at the low end of the address
  function automatic logic [ADDR_W-1:0] addr_push(input logic [ADDR_W-1:0] a,
                                                  input logic [7:0] b);
    return {a[ADDR_W-9:0], b};
  endfunction

  function automatic logic [7:0] status_of(input logic wen);
    return {6'b0, wen, 1'b0};
  endfunction

  function automatic logic takes_addr(input logic [7:0] op);
    return (op == OP_STORE) || (op == OP_FETCH);
  endfunction
endpackage

// File: rtl/sfl_ram.sv
module sfl_ram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/sfl_seq.sv
module sfl_seq
  import sfl_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic [7:0]       rd_data,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic             ev_cmd,
  output logic             ev_addr,
  output logic             ev_data,
  output logic             ev_end,
  output logic             cmd_vld,
  output logic [7:0]       cmd_q,
  output logic [CNT_W-1:0] abits,
  output logic             wel
);
  logic [ADDR_W-1:0] addr_q;
  logic              take;
  logic [7:0]        reply;

  assign take    = rx_valid && !cs_n;
  assign ev_cmd  = take && !cmd_vld;
  assign ev_addr = take && cmd_vld && (abits != '0);
  assign ev_data = take && cmd_vld && (abits == '0);
  assign ev_end  = cs_n && cmd_vld;
  assign mem_we  = ev_data && (cmd_q == OP_STORE) && wel;
  assign mem_addr = addr_q[AW-1:0];

  always_comb begin
    reply = 8'h00;
    if (ev_data) begin
      if (cmd_q == OP_FETCH)     reply = rd_data;
      else if (cmd_q == OP_STAT) reply = status_of(wel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= 8'h00;
      cmd_vld  <= 1'b0;
      cmd_q    <= 8'h00;
      abits    <= '0;
      addr_q   <= '0;
      wel      <= 1'b0;
    end else begin
      tx_valid <= take;
      tx_byte  <= take ? reply : 8'h00;
      if (cs_n) begin
        cmd_vld <= 1'b0;
        abits   <= '0;
        if (ev_end && cmd_q == OP_STORE) wel <= 1'b0;
      end else if (ev_cmd) begin
        cmd_q   <= rx_byte;
        cmd_vld <= 1'b1;
        addr_q  <= '0;
        abits   <= takes_addr(rx_byte) ? CNT_W'(ADDR_W) : '0;
        if (rx_byte == OP_WEN)  wel <= 1'b1;
        if (rx_byte == OP_WDIS) wel <= 1'b0;
      end else if (ev_addr) begin
        addr_q <= addr_push(addr_q, rx_byte);
        abits  <= abits - CNT_W'(8);
      end else if (ev_data && takes_addr(cmd_q)) begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfl_flash_slave.sv
module sfl_flash_slave
  import sfl_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  logic              mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0]        rd_data;
  logic              ev_cmd, ev_addr, ev_data, ev_end, cmd_vld, wel;
  logic [7:0]        cmd_q;
  logic [CNT_W-1:0]  abits;

  sfl_seq #(.AW(MEM_AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rd_data(rd_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .ev_cmd(ev_cmd), .ev_addr(ev_addr), .ev_data(ev_data), .ev_end(ev_end),
    .cmd_vld(cmd_vld), .cmd_q(cmd_q), .abits(abits), .wel(wel)
  );

  sfl_ram #(.AW(MEM_AW)) ram_i (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(rx_byte), .rdata(rd_data)
  );
endmodule

// File: rtl/sfl_checker.sv
module sfl_checker
  import sfl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rx_valid,
  input logic [7:0]       rx_byte,
  input logic             tx_valid,
  input logic [7:0]       tx_byte,
  input logic             ev_cmd,
  input logic             ev_addr,
  input logic             ev_data,
  input logic             ev_end,
  input logic             mem_we,
  input logic             cmd_vld,
  input logic [7:0]       cmd_q,
  input logic [CNT_W-1:0] abits,
  input logic             wel
);
  p_reply_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cs_n) |=> tx_valid);
  p_hdr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd || ev_addr) |=> (tx_byte == 8'h00));
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr |=> (abits == $past(abits) - CNT_W'(8)));
  p_guard_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel);
  p_wen_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd && rx_byte == 8'h06) |=> wel);
  p_wdis_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd && rx_byte == 8'h04) |=> !wel);
  p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_end && cmd_q == 8'h02) |=> !wel);
  p_other_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data && cmd_q != 8'h03 && cmd_q != 8'h05) |=> (tx_byte == 8'h00));
  p_deselect_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!tx_valid && !cmd_vld));
endmodule

bind sfl_flash_slave sfl_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
  .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .ev_cmd(ev_cmd), .ev_addr(ev_addr), .ev_data(ev_data), .ev_end(ev_end),
  .mem_we(mem_we), .cmd_vld(cmd_vld), .cmd_q(cmd_q), .abits(abits), .wel(wel)
);

// File: tb/sfl_flash_slave_tb.sv
module sfl_flash_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_valid;
  logic [7:0] tx_byte;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sfl_flash_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    r = tx_byte;
    chk("R2 reply strobe", int'(tx_valid), 1);
  endtask

  task automatic sel();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic desel();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic single(input logic [7:0] op);
    logic [7:0] r;
    sel();
    xfer(op, r);
    desel();
  endtask

  task automatic header(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] r;
    xfer(op, r);        chk("R3 command reply", r, 0);
    xfer(a[23:16], r);  chk("R3 address reply", r, 0);
    xfer(a[15:8], r);   chk("R3 address reply", r, 0);
    xfer(a[7:0], r);    chk("R3 address reply", r, 0);
  endtask

  task automatic write2(input logic [23:0] a, input logic [7:0] d0, d1);
    logic [7:0] r;
    sel();
    header(8'h02, a);
    xfer(d0, r);
    xfer(d1, r);
    desel();
  endtask

  task automatic read2(input string req, input logic [23:0] a,
                       input logic [7:0] e0, e1);
    logic [7:0] r;
    sel();
    header(8'h03, a);
    xfer(8'h00, r); chk(req, r, e0);
    xfer(8'h00, r); chk(req, r, e1);
    desel();
  endtask

  task automatic status_is(input string req, input logic [7:0] e);
    logic [7:0] r;
    sel();
    xfer(8'h05, r);
    xfer(8'h00, r); chk(req, r, e);
    xfer(8'h00, r); chk(req, r, e);
    desel();
  endtask

  task automatic t_reset();
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 tx_byte", tx_byte, 0);
    status_is("R1 latch clear", 8'h00);
  endtask

  task automatic t_latch();
    single(8'h06);
    status_is("R7 status after set", 8'h02);
    single(8'h04);
    status_is("R8 status after clear", 8'h00);
  endtask

  task automatic t_store_fetch();
    single(8'h06);
    write2(24'h000010, 8'h11, 8'h22);
    single(8'h06);
    write2(24'h000020, 8'h01, 8'h02);
    read2("R5 stored data", 24'h000010, 8'h11, 8'h22);
    read2("R4 fetch second area", 24'h000020, 8'h01, 8'h02);
    status_is("R9 latch dropped after store", 8'h00);
  endtask

  task automatic t_blocked();
    write2(24'h000010, 8'hEE, 8'hDD);
    read2("R6 store without latch", 24'h000010, 8'h11, 8'h22);
  endtask

  task automatic t_wrap();
    single(8'h06);
    write2(24'h0000FF, 8'hA5, 8'h5A);
    read2("R4 address wrap", 24'h0001FF, 8'hA5, 8'h5A);
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    single(8'h06);
    sel();
    xfer(8'h9F, r); chk("R10 unknown reply", r, 0);
    xfer(8'h00, r); chk("R10 unknown reply", r, 0);
    xfer(8'h10, r); chk("R10 unknown reply", r, 0);
    xfer(8'h77, r); chk("R10 unknown reply", r, 0);
    desel();
    status_is("R10 status kept", 8'h02);
    read2("R10 memory kept", 24'h000010, 8'h11, 8'h22);
    single(8'h04);
  endtask

  task automatic t_deselect();
    logic [7:0] r;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = 8'h06;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R11 strobe while deselected", int'(tx_valid), 0);
    status_is("R11 deselected byte had no effect", 8'h00);
    sel();
    header(8'h03, 24'h000010);
    xfer(8'h00, r); chk("R4 fetch before cut", r, 8'h11);
    desel();
    sel();
    xfer(8'h05, r); chk("R11 new command reply", r, 0);
    xfer(8'h00, r); chk("R11 new command is status", r, 0);
    desel();
  endtask

  task automatic t_collide();
    logic [7:0] r;
    single(8'h06);
    sel();
    header(8'h02, 24'h000020);
    xfer(8'h55, r);
    @(negedge clk);
    cs_n     = 1'b1;
    rx_valid = 1'b1;
    rx_byte  = 8'h66;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R11 byte at deselect edge", int'(tx_valid), 0);
    @(negedge clk);
    read2("R11 byte at deselect not stored", 24'h000020, 8'h55, 8'h02);
    status_is("R9 latch dropped at deselect", 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_store_fetch();
    t_blocked();
    t_wrap();
    t_unknown();
    t_deselect();
    t_collide();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule